// File: doc/BRIEF.md
# Single-Stage Virtual-Channel Packet Router

This block is one node of an on-chip packet network. It has `PORTS` input links and `PORTS` output links. Every link carries flits forward and credits backward. A flit's control fields (valid, head marker, tail marker, virtual channel, destination) travel on their own wires beside the payload, so the payload width is spent on data alone. Each input keeps one flit buffer per virtual channel.

A head flit selects its output port by indexing a routing table with its destination. The table is a plain input vector loaded by the user. In one clock cycle the router looks up the route, arbitrates and crosses the switch. A flit that sits at the head of its buffer during a cycle is registered onto the output link at the next clock edge. A flit keeps its virtual channel through the router. Each output VC keeps a credit count for the downstream buffer and sends only while that count is above zero.

Two small state machines control packet ownership. Each input VC moves from `IVC_WAIT_HEAD` to `IVC_STREAM` when a head flit that is not also a tail leaves its buffer. It then holds the looked-up port and returns to `IVC_WAIT_HEAD` when the tail leaves. Each output VC moves from `OVC_FREE` to `OVC_HELD` when such a head is sent through it, recording the owning input. It returns to `OVC_FREE` when the tail is sent. A single-flit packet leaves both machines where they were.

Top module: `vc_router`

## Requirements
- R1: An uncontended flit with credit available, written into an input buffer at clock edge k, appears on its output link at edge k+1.
- R2: A head flit leaves on output port `route_table[dst*PORT_W +: PORT_W]`, where `dst` is its destination field and `PORT_W` is `$clog2(PORTS)`.
- R3: The head marker, tail marker, VC number, destination field and payload arrive on the output unchanged. The output VC equals the input VC.
- R4: At the edge where a flit leaves input port i, `rx_credit[i]` pulses for exactly one cycle and `rx_credit_vc` slice i carries that flit's VC. A flit that stays buffered returns no credit.
- R5: Each output-VC credit count resets to `BUF_DEPTH` and drops by one per flit sent. With no credits returned, at most `BUF_DEPTH` flits leave on that output VC, and later flits wait in their input buffer.
- R6: Each cycle with `tx_credit[o]` high and `tx_credit_vc` slice o equal to v adds one credit to output VC (o,v), and that credit lets exactly one more waiting flit leave. A send and a return on the same output VC in the same cycle leave the count unchanged.
- R7: After a non-tail head wins output VC (o,v), that output VC serves only the owning input until the owner's tail has passed. Heads from other inputs on VC v for port o wait. Body and tail flits follow the stored port and ignore their own destination field.
- R8: Each output grants among requesting inputs in round-robin order, and the priority moves just past the winner after every grant. Two inputs that keep requesting one output are served alternately.
- R9: In every cycle each output sends at most one flit and each input releases at most one flit. Each input chooses among its ready VCs in round-robin order.
- R10: After reset, all `tx_valid` and `rx_credit` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| route_table | input | 2**DST_W * PORT_W | Output port for each destination, entry d at bits d*PORT_W |
| rx_valid | input | PORTS | Flit present on input link i |
| rx_head | input | PORTS | Head marker of incoming flit |
| rx_tail | input | PORTS | Tail marker of incoming flit |
| rx_vc | input | PORTS*VC_W | VC of incoming flit |
| rx_dst | input | PORTS*DST_W | Destination of incoming flit |
| rx_data | input | PORTS*FLIT_W | Payload of incoming flit |
| rx_credit | output | PORTS | Credit returned to the upstream sender of link i |
| rx_credit_vc | output | PORTS*VC_W | VC of the returned credit |
| tx_valid | output | PORTS | Flit present on output link o |
| tx_head | output | PORTS | Head marker of outgoing flit |
| tx_tail | output | PORTS | Tail marker of outgoing flit |
| tx_vc | output | PORTS*VC_W | VC of outgoing flit |
| tx_dst | output | PORTS*DST_W | Destination of outgoing flit |
| tx_data | output | PORTS*FLIT_W | Payload of outgoing flit |
| tx_credit | input | PORTS | Credit from the downstream receiver of link o |
| tx_credit_vc | input | PORTS*VC_W | VC of that credit |

## Verification
A credit counter that drifts first shows as a stall on one output VC, or as one flit too many before the stall. Either is visible in the count of `tx_valid` pulses within a few cycles of the `BUF_DEPTH`-th send. A lock that stays set or is lost shows at the next competing head: that head is held forever, or a foreign flit lands in the middle of a packet. A wrong stored route shows as soon as the first body flit, which leaves on a port that its own destination field would not pick. A stale arbiter pointer breaks the alternation between two contending inputs within two grants.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

    typedef enum logic {
        IVC_WAIT_HEAD = 1'b0,
        IVC_STREAM    = 1'b1
    } ivc_state_e;

    typedef enum logic {
        OVC_FREE = 1'b0,
        OVC_HELD = 1'b1
    } ovc_state_e;

endpackage

// File: rtl/vcr_rr_arb.sv
module vcr_rr_arb #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);

    logic [IW-1:0] ptr_q;

    always_comb begin
        int idx;
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr_q) + k;
            if (idx >= N) idx = idx - N;
            if (!any && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                gnt_idx  = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance && any) begin
            ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + IW'(1);
        end
    end

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_grant_to_requester_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    assert_no_idle_with_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> any);

endmodule

// File: rtl/vcr_in_vc.sv
module vcr_in_vc
    import vcr_pkg::*;
#(
    parameter int FLIT_W = 16,
    parameter int DST_W  = 3,
    parameter int PORT_W = 2,
    parameter int DEPTH  = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_head,
    input  logic              wr_tail,
    input  logic [DST_W-1:0]  wr_dst,
    input  logic [FLIT_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] lookup_port,
    output logic              hd_valid,
    output logic              hd_head,
    output logic              hd_tail,
    output logic [DST_W-1:0]  hd_dst,
    output logic [FLIT_W-1:0] hd_data,
    output logic [PORT_W-1:0] tgt_port
);

    logic              mem_head [DEPTH];
    logic              mem_tail [DEPTH];
    logic [DST_W-1:0]  mem_dst  [DEPTH];
    logic [FLIT_W-1:0] mem_data [DEPTH];

    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;

    ivc_state_e        state_q, state_n;
    logic [PORT_W-1:0] route_q, route_n;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_head[wr_ptr_q] <= wr_head;
            mem_tail[wr_ptr_q] <= wr_tail;
            mem_dst[wr_ptr_q]  <= wr_dst;
            mem_data[wr_ptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (wr_en) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
            if (rd_en) rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
            if (wr_en && !rd_en)      count_q <= count_q + CW'(1);
            else if (!wr_en && rd_en) count_q <= count_q - CW'(1);
        end
    end

    assign hd_valid = (count_q != '0);
    assign hd_head  = mem_head[rd_ptr_q];
    assign hd_tail  = mem_tail[rd_ptr_q];
    assign hd_dst   = mem_dst[rd_ptr_q];
    assign hd_data  = mem_data[rd_ptr_q];

    // packet-ownership state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IVC_WAIT_HEAD;
            route_q <= '0;
        end else begin
            state_q <= state_n;
            route_q <= route_n;
        end
    end

    always_comb begin
        state_n = state_q;
        route_n = route_q;
        unique case (state_q)
            IVC_WAIT_HEAD: begin
                if (rd_en && hd_head && !hd_tail) begin
                    state_n = IVC_STREAM;
                    route_n = lookup_port;
                end
            end
            IVC_STREAM: begin
                if (rd_en && hd_tail) state_n = IVC_WAIT_HEAD;
            end
        endcase
    end

    // outputs
    always_comb begin
        tgt_port = (state_q == IVC_STREAM) ? route_q : lookup_port;
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (count_q != CW'(DEPTH)) || rd_en);

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> hd_valid);

    assert_head_matches_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hd_valid |-> (hd_head == (state_q == IVC_WAIT_HEAD)));

endmodule

// File: rtl/vcr_out_vc.sv
module vcr_out_vc
    import vcr_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int PORT_W = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic              send_head,
    input  logic              send_tail,
    input  logic [PORT_W-1:0] send_src,
    input  logic              credit_ret,
    output logic              has_credit,
    output logic              held,
    output logic [PORT_W-1:0] owner
);

    ovc_state_e        state_q, state_n;
    logic [PORT_W-1:0] owner_q, owner_n;
    logic [CW-1:0]     cred_q, cred_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OVC_FREE;
            owner_q <= '0;
            cred_q  <= CW'(DEPTH);
        end else begin
            state_q <= state_n;
            owner_q <= owner_n;
            cred_q  <= cred_n;
        end
    end

    always_comb begin
        state_n = state_q;
        owner_n = owner_q;
        unique case (state_q)
            OVC_FREE: begin
                if (send && send_head && !send_tail) begin
                    state_n = OVC_HELD;
                    owner_n = send_src;
                end
            end
            OVC_HELD: begin
                if (send && send_tail) state_n = OVC_FREE;
            end
        endcase

        unique case ({send, credit_ret})
            2'b10:   cred_n = cred_q - CW'(1);
            2'b01:   cred_n = cred_q + CW'(1);
            default: cred_n = cred_q;
        endcase
    end

    // outputs
    always_comb begin
        has_credit = (cred_q != '0);
        held       = (state_q == OVC_HELD);
        owner      = owner_q;
    end

    assert_no_send_without_credit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        send |-> (cred_q != '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_ret && !send) |-> (cred_q < CW'(DEPTH)));

    assert_owner_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OVC_HELD && send) |-> (send_src == owner_q && !send_head));

endmodule

// File: rtl/vc_router.sv
module vc_router
    import vcr_pkg::*;
#(
    parameter int PORTS     = 4,
    parameter int VCS       = 2,
    parameter int FLIT_W    = 16,
    parameter int BUF_DEPTH = 4,
    parameter int DST_W     = 3,
    localparam int PORT_W  = (PORTS > 1) ? $clog2(PORTS) : 1,
    localparam int VC_W    = (VCS > 1) ? $clog2(VCS) : 1,
    localparam int NUM_DST = 1 << DST_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_DST*PORT_W-1:0] route_table,
    input  logic [PORTS-1:0]          rx_valid,
    input  logic [PORTS-1:0]          rx_head,
    input  logic [PORTS-1:0]          rx_tail,
    input  logic [PORTS*VC_W-1:0]     rx_vc,
    input  logic [PORTS*DST_W-1:0]    rx_dst,
    input  logic [PORTS*FLIT_W-1:0]   rx_data,
    output logic [PORTS-1:0]          rx_credit,
    output logic [PORTS*VC_W-1:0]     rx_credit_vc,
    output logic [PORTS-1:0]          tx_valid,
    output logic [PORTS-1:0]          tx_head,
    output logic [PORTS-1:0]          tx_tail,
    output logic [PORTS*VC_W-1:0]     tx_vc,
    output logic [PORTS*DST_W-1:0]    tx_dst,
    output logic [PORTS*FLIT_W-1:0]   tx_data,
    input  logic [PORTS-1:0]          tx_credit,
    input  logic [PORTS*VC_W-1:0]     tx_credit_vc
);

    // input VC buffer heads
    logic              hd_valid [PORTS][VCS];
    logic              hd_head  [PORTS][VCS];
    logic              hd_tail  [PORTS][VCS];
    logic [DST_W-1:0]  hd_dst   [PORTS][VCS];
    logic [FLIT_W-1:0] hd_data  [PORTS][VCS];
    logic [PORT_W-1:0] tgt      [PORTS][VCS];
    logic [PORT_W-1:0] lookup   [PORTS][VCS];
    logic              wr_en    [PORTS][VCS];
    logic              rd_en    [PORTS][VCS];

    // output VC status
    logic              ovc_credit [PORTS][VCS];
    logic              ovc_held   [PORTS][VCS];
    logic [PORT_W-1:0] ovc_owner  [PORTS][VCS];
    logic              ovc_send   [PORTS][VCS];
    logic              ovc_ret    [PORTS][VCS];

    // allocation
    logic [VCS-1:0]    elig_vec  [PORTS];
    logic [VCS-1:0]    in_gnt    [PORTS];
    logic [VC_W-1:0]   sel_v     [PORTS];
    logic              in_any    [PORTS];
    logic [PORT_W-1:0] sel_o     [PORTS];
    logic [PORTS-1:0]  out_req   [PORTS];
    logic [PORTS-1:0]  out_gnt   [PORTS];
    logic [PORT_W-1:0] out_idx   [PORTS];
    logic              out_any   [PORTS];
    logic [PORTS-1:0]  in_col    [PORTS];
    logic [PORTS-1:0]  sent;

    // switch mux
    logic              mx_head [PORTS];
    logic              mx_tail [PORTS];
    logic [VC_W-1:0]   mx_vc   [PORTS];
    logic [DST_W-1:0]  mx_dst  [PORTS];
    logic [FLIT_W-1:0] mx_data [PORTS];

    // output registers
    logic              tx_valid_q [PORTS];
    logic              tx_head_q  [PORTS];
    logic              tx_tail_q  [PORTS];
    logic [VC_W-1:0]   tx_vc_q    [PORTS];
    logic [DST_W-1:0]  tx_dst_q   [PORTS];
    logic [FLIT_W-1:0] tx_data_q  [PORTS];
    logic              rx_cr_q    [PORTS];
    logic [VC_W-1:0]   rx_cr_vc_q [PORTS];

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            for (int v = 0; v < VCS; v++) begin
                wr_en[i][v]  = rx_valid[i] && (rx_vc[i*VC_W +: VC_W] == VC_W'(v));
                rd_en[i][v]  = sent[i] && (sel_v[i] == VC_W'(v));
                lookup[i][v] = route_table[int'(hd_dst[i][v])*PORT_W +: PORT_W];
            end
        end
    end

    generate
        for (genvar gi = 0; gi < PORTS; gi++) begin : g_in
            for (genvar gv = 0; gv < VCS; gv++) begin : g_vc
                vcr_in_vc #(
                    .FLIT_W (FLIT_W),
                    .DST_W  (DST_W),
                    .PORT_W (PORT_W),
                    .DEPTH  (BUF_DEPTH)
                ) u_buf (
                    .clk         (clk),
                    .rst_n       (rst_n),
                    .wr_en       (wr_en[gi][gv]),
                    .wr_head     (rx_head[gi]),
                    .wr_tail     (rx_tail[gi]),
                    .wr_dst      (rx_dst[gi*DST_W +: DST_W]),
                    .wr_data     (rx_data[gi*FLIT_W +: FLIT_W]),
                    .rd_en       (rd_en[gi][gv]),
                    .lookup_port (lookup[gi][gv]),
                    .hd_valid    (hd_valid[gi][gv]),
                    .hd_head     (hd_head[gi][gv]),
                    .hd_tail     (hd_tail[gi][gv]),
                    .hd_dst      (hd_dst[gi][gv]),
                    .hd_data     (hd_data[gi][gv]),
                    .tgt_port    (tgt[gi][gv])
                );
            end

            vcr_rr_arb #(.N(VCS)) u_vc_arb (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (elig_vec[gi]),
                .advance (sent[gi]),
                .gnt     (in_gnt[gi]),
                .gnt_idx (sel_v[gi]),
                .any     (in_any[gi])
            );

            assert_one_output_per_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(in_col[gi]));
        end

        for (genvar go = 0; go < PORTS; go++) begin : g_out
            for (genvar gv = 0; gv < VCS; gv++) begin : g_vc
                vcr_out_vc #(
                    .DEPTH  (BUF_DEPTH),
                    .PORT_W (PORT_W)
                ) u_ovc (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .send       (ovc_send[go][gv]),
                    .send_head  (mx_head[go]),
                    .send_tail  (mx_tail[go]),
                    .send_src   (out_idx[go]),
                    .credit_ret (ovc_ret[go][gv]),
                    .has_credit (ovc_credit[go][gv]),
                    .held       (ovc_held[go][gv]),
                    .owner      (ovc_owner[go][gv])
                );
            end

            vcr_rr_arb #(.N(PORTS)) u_port_arb (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (out_req[go]),
                .advance (1'b1),
                .gnt     (out_gnt[go]),
                .gnt_idx (out_idx[go]),
                .any     (out_any[go])
            );

            assign tx_valid[go]                    = tx_valid_q[go];
            assign tx_head[go]                     = tx_head_q[go];
            assign tx_tail[go]                     = tx_tail_q[go];
            assign tx_vc[go*VC_W +: VC_W]          = tx_vc_q[go];
            assign tx_dst[go*DST_W +: DST_W]       = tx_dst_q[go];
            assign tx_data[go*FLIT_W +: FLIT_W]    = tx_data_q[go];
            assign rx_credit[go]                   = rx_cr_q[go];
            assign rx_credit_vc[go*VC_W +: VC_W]   = rx_cr_vc_q[go];

            assert_route_from_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (out_any[go] && mx_head[go]) |->
                    (route_table[int'(mx_dst[go])*PORT_W +: PORT_W] == PORT_W'(go)));
        end
    endgenerate

    // eligibility: flit present, credit available, head may claim only a free output VC
    always_comb begin
        int o;
        for (int i = 0; i < PORTS; i++) begin
            for (int v = 0; v < VCS; v++) begin
                o = int'(tgt[i][v]);
                elig_vec[i][v] = hd_valid[i][v] && ovc_credit[o][v] &&
                                 (!hd_head[i][v] || !ovc_held[o][v]);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < PORTS; i++) begin
            sel_o[i] = tgt[i][sel_v[i]];
        end
        for (int o = 0; o < PORTS; o++) begin
            for (int i = 0; i < PORTS; i++) begin
                out_req[o][i] = in_any[i] && (sel_o[i] == PORT_W'(o));
                in_col[i][o]  = out_gnt[o][i];
            end
        end
        for (int i = 0; i < PORTS; i++) begin
            sent[i] = (in_col[i] != '0);
        end
    end

    always_comb begin
        int w;
        int wv;
        for (int o = 0; o < PORTS; o++) begin
            w          = int'(out_idx[o]);
            wv         = int'(sel_v[w]);
            mx_vc[o]   = sel_v[w];
            mx_head[o] = hd_head[w][wv];
            mx_tail[o] = hd_tail[w][wv];
            mx_dst[o]  = hd_dst[w][wv];
            mx_data[o] = hd_data[w][wv];
            for (int v = 0; v < VCS; v++) begin
                ovc_send[o][v] = out_any[o] && (mx_vc[o] == VC_W'(v));
                ovc_ret[o][v]  = tx_credit[o] && (tx_credit_vc[o*VC_W +: VC_W] == VC_W'(v));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int o = 0; o < PORTS; o++) begin
                tx_valid_q[o] <= 1'b0;
                tx_head_q[o]  <= 1'b0;
                tx_tail_q[o]  <= 1'b0;
                tx_vc_q[o]    <= '0;
                tx_dst_q[o]   <= '0;
                tx_data_q[o]  <= '0;
                rx_cr_q[o]    <= 1'b0;
                rx_cr_vc_q[o] <= '0;
            end
        end else begin
            for (int o = 0; o < PORTS; o++) begin
                tx_valid_q[o] <= out_any[o];
                if (out_any[o]) begin
                    tx_head_q[o] <= mx_head[o];
                    tx_tail_q[o] <= mx_tail[o];
                    tx_vc_q[o]   <= mx_vc[o];
                    tx_dst_q[o]  <= mx_dst[o];
                    tx_data_q[o] <= mx_data[o];
                end
            end
            for (int i = 0; i < PORTS; i++) begin
                rx_cr_q[i]    <= sent[i];
                rx_cr_vc_q[i] <= sel_v[i];
            end
        end
    end

endmodule

// File: tb/vc_router_bench.sv
module vc_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PORTS  = 4;
    localparam int VCS    = 2;
    localparam int FLIT_W = 16;
    localparam int DEPTH  = 4;
    localparam int DST_W  = 3;
    localparam int PORT_W = 2;
    localparam int VC_W   = 1;
    localparam int NDST   = 8;
    localparam int NVEC   = 8;

    // vector: port[21:20] vc[19] dst[18:16] data[15:0]
    localparam logic [21:0] VECS [NVEC] = '{
        {2'd0, 1'b0, 3'd0, 16'hC000},
        {2'd1, 1'b1, 3'd2, 16'hC111},
        {2'd2, 1'b0, 3'd3, 16'hC222},
        {2'd3, 1'b1, 3'd1, 16'hC333},
        {2'd0, 1'b1, 3'd6, 16'hC444},
        {2'd1, 1'b0, 3'd7, 16'hC555},
        {2'd2, 1'b1, 3'd4, 16'hC666},
        {2'd3, 1'b0, 3'd5, 16'hC777}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NDST*PORT_W-1:0]  route_table;
    logic [PORTS-1:0]        rx_valid, rx_head, rx_tail;
    logic [PORTS*VC_W-1:0]   rx_vc;
    logic [PORTS*DST_W-1:0]  rx_dst;
    logic [PORTS*FLIT_W-1:0] rx_data;
    logic [PORTS-1:0]        rx_credit;
    logic [PORTS*VC_W-1:0]   rx_credit_vc;
    logic [PORTS-1:0]        tx_valid, tx_head, tx_tail;
    logic [PORTS*VC_W-1:0]   tx_vc;
    logic [PORTS*DST_W-1:0]  tx_dst;
    logic [PORTS*FLIT_W-1:0] tx_data;
    logic [PORTS-1:0]        tx_credit;
    logic [PORTS*VC_W-1:0]   tx_credit_vc;

    int checks = 0;
    int failures = 0;
    int tx_cnt [PORTS];
    int cr_cnt [PORTS];
    logic [15:0] log_data [16];
    int log_n = 0;
    int log_port = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    vc_router #(
        .PORTS(PORTS), .VCS(VCS), .FLIT_W(FLIT_W), .BUF_DEPTH(DEPTH), .DST_W(DST_W)
    ) u_vc_router (
        .clk(clk), .rst_n(rst_n), .route_table(route_table),
        .rx_valid(rx_valid), .rx_head(rx_head), .rx_tail(rx_tail),
        .rx_vc(rx_vc), .rx_dst(rx_dst), .rx_data(rx_data),
        .rx_credit(rx_credit), .rx_credit_vc(rx_credit_vc),
        .tx_valid(tx_valid), .tx_head(tx_head), .tx_tail(tx_tail),
        .tx_vc(tx_vc), .tx_dst(tx_dst), .tx_data(tx_data),
        .tx_credit(tx_credit), .tx_credit_vc(tx_credit_vc)
    );

    function automatic int route_of(input int d);
        return (d * 3 + 1) % 4;
    endfunction

    always @(negedge clk) begin
        for (int p = 0; p < PORTS; p++) begin
            if (tx_valid[p]) tx_cnt[p]++;
            if (rx_credit[p]) cr_cnt[p]++;
        end
        if (log_port >= 0 && tx_valid[log_port]) begin
            if (log_n < 16) log_data[log_n] = tx_data[log_port*FLIT_W +: FLIT_W];
            log_n++;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_rx();
        rx_valid = '0; rx_head = '0; rx_tail = '0;
        rx_vc = '0; rx_dst = '0; rx_data = '0;
    endtask

    task automatic put_flit(input int p, input int v, input int d, input bit h, input bit t,
                            input logic [15:0] data);
        rx_valid[p] = 1'b1;
        rx_head[p]  = h;
        rx_tail[p]  = t;
        rx_vc[p*VC_W +: VC_W]       = VC_W'(v);
        rx_dst[p*DST_W +: DST_W]    = DST_W'(d);
        rx_data[p*FLIT_W +: FLIT_W] = data;
    endtask

    task automatic give_credit(input int o, input int v, input int n);
        for (int k = 0; k < n; k++) begin
            tx_credit = '0;
            tx_credit[o] = 1'b1;
            tx_credit_vc[o*VC_W +: VC_W] = VC_W'(v);
            tick();
        end
        tx_credit = '0;
        tx_credit_vc = '0;
    endtask

    task automatic zero_counts();
        for (int p = 0; p < PORTS; p++) begin
            tx_cnt[p] = 0;
            cr_cnt[p] = 0;
        end
        log_n = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int d = 0; d < NDST; d++) route_table[d*PORT_W +: PORT_W] = PORT_W'(route_of(d));
        clear_rx();
        tx_credit = '0;
        tx_credit_vc = '0;
        zero_counts();
        tick();
        tick();
        rst_n = 1'b1;
        tick();

        // R10: reset state
        check(tx_valid == '0, "R10 tx_valid after reset", 32'(tx_valid), 0);
        check(rx_credit == '0, "R10 rx_credit after reset", 32'(rx_credit), 0);

        // vector walk: single-flit packets, R1 R2 R3 R4
        for (int k = 0; k < NVEC; k++) begin
            int p;
            int v;
            int d;
            int o;
            logic [15:0] data;
            p = int'(VECS[k][21:20]);
            v = int'(VECS[k][19]);
            d = int'(VECS[k][18:16]);
            data = VECS[k][15:0];
            o = route_of(d);
            clear_rx();
            put_flit(p, v, d, 1'b1, 1'b1, data);
            tick();
            clear_rx();
            tick();
            check(tx_valid == PORTS'(1 << o), "R1 R2 output port one cycle later", 32'(tx_valid), 32'(1 << o));
            check(tx_data[o*FLIT_W +: FLIT_W] == data, "R3 payload", 32'(tx_data[o*FLIT_W +: FLIT_W]), 32'(data));
            check(tx_head[o] && tx_tail[o], "R3 head and tail markers", {30'd0, tx_head[o], tx_tail[o]}, 3);
            check(tx_vc[o*VC_W +: VC_W] == VC_W'(v) && tx_dst[o*DST_W +: DST_W] == DST_W'(d),
                  "R3 vc and dst", {28'd0, tx_vc[o*VC_W +: VC_W], tx_dst[o*DST_W +: DST_W]}, 32'(v * 8 + d));
            check(rx_credit == PORTS'(1 << p) && rx_credit_vc[p*VC_W +: VC_W] == VC_W'(v),
                  "R4 upstream credit", {27'd0, rx_credit_vc[p*VC_W +: VC_W], rx_credit}, 32'(v * 16 + (1 << p)));
            give_credit(o, v, 1);
        end

        // R7: lock of output 2 VC1 by input 0
        tick();
        zero_counts();
        log_port = 2;
        put_flit(0, 1, 3, 1'b1, 1'b0, 16'h0A01);
        tick();
        clear_rx();
        put_flit(2, 1, 3, 1'b1, 1'b1, 16'h0B02);
        tick();
        clear_rx();
        tick();
        put_flit(0, 1, 0, 1'b0, 1'b0, 16'h0A02);
        tick();
        clear_rx();
        put_flit(0, 1, 0, 1'b0, 1'b1, 16'h0A03);
        tick();
        clear_rx();
        for (int k = 0; k < 6; k++) tick();
        check(log_n == 4, "R7 flit count on locked port", 32'(log_n), 4);
        check(log_data[0] == 16'h0A01 && log_data[1] == 16'h0A02,
              "R7 owner head then body", {log_data[0], log_data[1]}, 32'h0A010A02);
        check(log_data[2] == 16'h0A03 && log_data[3] == 16'h0B02,
              "R7 competing head waits for tail", {log_data[2], log_data[3]}, 32'h0A030B02);
        check(tx_cnt[1] == 0, "R7 body ignores own dst", 32'(tx_cnt[1]), 0);
        check(cr_cnt[0] == 3 && cr_cnt[2] == 1, "R4 credits per input", 32'(cr_cnt[0] * 16 + cr_cnt[2]), 32'h31);
        log_port = -1;
        give_credit(2, 1, 4);

        // R8 R9: inputs 1 and 3 contend for output 0
        zero_counts();
        log_port = 0;
        put_flit(1, 0, 1, 1'b1, 1'b1, 16'h1101);
        put_flit(3, 1, 5, 1'b1, 1'b1, 16'h3301);
        tick();
        clear_rx();
        put_flit(1, 0, 1, 1'b1, 1'b1, 16'h1102);
        put_flit(3, 1, 5, 1'b1, 1'b1, 16'h3302);
        tick();
        clear_rx();
        for (int k = 0; k < 6; k++) tick();
        check(log_n == 4, "R9 one flit per cycle on output 0", 32'(log_n), 4);
        for (int k = 0; k < 3; k++) begin
            check(log_data[k][15:12] != log_data[k+1][15:12], "R8 alternation",
                  32'(log_data[k+1][15:12]), 32'(log_data[k][15:12]));
        end
        check(cr_cnt[1] == 2 && cr_cnt[3] == 2, "R9 releases per input", 32'(cr_cnt[1] * 16 + cr_cnt[3]), 32'h22);
        log_port = -1;
        give_credit(0, 0, 2);
        give_credit(0, 1, 2);

        // R5 R6: credit exhaustion on output 1 VC0
        zero_counts();
        for (int k = 0; k < 4; k++) begin
            clear_rx();
            put_flit(0, 0, 0, 1'b1, 1'b1, 16'h5000 + 16'(k));
            tick();
        end
        clear_rx();
        tick();
        for (int k = 0; k < 3; k++) begin
            clear_rx();
            put_flit(0, 0, 0, 1'b1, 1'b1, 16'h5100 + 16'(k));
            tick();
        end
        clear_rx();
        for (int k = 0; k < 4; k++) tick();
        check(tx_cnt[1] == 4, "R5 stall after BUF_DEPTH sends", 32'(tx_cnt[1]), 4);
        check(cr_cnt[0] == 4, "R4 no credit for waiting flits", 32'(cr_cnt[0]), 4);
        give_credit(1, 0, 2);
        for (int k = 0; k < 5; k++) tick();
        check(tx_cnt[1] == 6, "R6 two returns release two flits", 32'(tx_cnt[1]), 6);
        give_credit(1, 0, 1);
        for (int k = 0; k < 4; k++) tick();
        check(tx_cnt[1] == 7, "R6 one return releases one flit", 32'(tx_cnt[1]), 7);
        check(tx_data[1*FLIT_W +: FLIT_W] == 16'h5102, "R5 order kept across stall",
              32'(tx_data[1*FLIT_W +: FLIT_W]), 32'h5102);
        give_credit(1, 0, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule